// File: doc/BRIEF.md
# Interleaved Component Table Sequencer

In a scan where colour components are interleaved, this block walks through the data units of each minimum coded unit (a "group") one at a time. For every data unit it names the component being decoded. That index also selects the DC predictor. The block also gives the Huffman table ID and the quantisation table ID assigned to that component. The entropy decoder, the dequantiser and the DC predictor logic downstream use these values while they decode the unit.

Header parsing is done elsewhere. A start pulse captures the scan configuration: the component count, each component's horizontal and vertical sampling factors, and each component's two table IDs. It also resets the sequence to the first data unit of component 0. After that, each advance pulse marks the end of one data unit and moves the sequence to the next unit. When the group is complete the sequence wraps back to component 0. If a configuration is out of range, the block enters a fault state and stays there until a later start pulse brings a valid configuration.

The controller has three states. ST_IDLE is the state after reset. ST_RUN means the sequence is stepping through units. ST_FAULT means the captured configuration was rejected. The transitions are:
- start_ok: any state to ST_RUN, taken on start when the configuration is valid.
- start_bad: any state to ST_FAULT, taken on start when the configuration is invalid.
- step: ST_RUN to ST_RUN on advance. This moves to the next unit, the next component, or back to the beginning of the group.
- hold: ST_IDLE and ST_FAULT stay where they are when start is absent.

Top module: `tsq_top`

## Requirements
- R1: After reset, and while the block is in ST_IDLE, `active`, `cfg_fault` and `grp_last` are 0, and `comp_sel`, `huff_id` and `quant_id` are 0.
- R2: On the clock edge where `start` is high and the configuration is valid, the block enters ST_RUN. In the cycle that follows, `active` is 1 and the current unit is unit 0 of component 0.
- R3: When `num_comp` is 2 or 3, component k stays on `comp_sel` for H_k×V_k consecutive data units. The sequence then moves to component k+1. Each advance pulse moves the sequence by exactly one unit.
- R4: In ST_RUN, `huff_id` and `quant_id` equal the IDs that were captured at start for the component shown on `comp_sel`. Component k's IDs occupy bits [2k+1:2k] of `cfg_huff` and of `cfg_quant`. Changes to any configuration input after start have no effect until the next start.
- R5: `grp_last` is 1 exactly during the last data unit of the group, and 0 during every other unit.
- R6: An advance during the last data unit returns the sequence to unit 0 of component 0.
- R7: When `num_comp` is 1, every group holds a single data unit of component 0 whatever its sampling factors are, so `grp_last` is 1 on every unit.
- R8: A configuration is invalid if any of the following holds: `num_comp` is 0; any used component has a factor outside 1..4; or the total number of units per group, the sum of H_k×V_k, exceeds 10. Each component's factors sit in bits [3k+2:3k] of `cfg_hf` and `cfg_vf`. Starting with an invalid configuration enters ST_FAULT. In that state `cfg_fault` is 1, `active` is 0, every other output is 0, and advance has no effect.
- R9: Advance is ignored in ST_IDLE and in ST_FAULT. When `start` and `advance` are high in the same cycle, `start` takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Captures the configuration and restarts the sequence |
| advance | input | 1 | Pulse at the end of each data unit |
| num_comp | input | 2 | Number of components in the scan (1 to 3) |
| cfg_hf | input | 9 | Horizontal sampling factors, 3 bits per component |
| cfg_vf | input | 9 | Vertical sampling factors, 3 bits per component |
| cfg_huff | input | 6 | Huffman table ID, 2 bits per component |
| cfg_quant | input | 6 | Quantisation table ID, 2 bits per component |
| comp_sel | output | 2 | Current component index, which also selects the DC predictor |
| huff_id | output | 2 | Huffman table ID for the current unit |
| quant_id | output | 2 | Quantisation table ID for the current unit |
| grp_last | output | 1 | High during the last data unit of the group |
| active | output | 1 | The sequencer is in ST_RUN |
| cfg_fault | output | 1 | The captured configuration was rejected |

## Verification
The assertions check the following properties on every cycle:
- A valid start lands on unit 0 of component 0.
- A rejected start lands in ST_FAULT.
- An advance on the final unit wraps the sequence to the beginning.
- An advance in the middle of a component's run keeps the component unchanged.
- The idle and fault states hold when there is no start.
- Any accepted configuration fits within ten units.

The bench scenarios are needed for everything else. These include the exact interleaving order for particular sampling factors and the mapping of each unit to its captured table IDs. They also cover the single-component collapse, the boundary between a total of ten units and eleven, and recovery from a fault through a later valid start.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
    localparam int NCOMP     = 3;
    localparam int SF_W      = 3;
    localparam int MAX_SF    = 4;
    localparam int MAX_UNITS = 10;
    localparam int TID_W     = 2;
    localparam int CIDX_W    = $clog2(NCOMP + 1);
    localparam int UNIT_W    = $clog2(MAX_UNITS + 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } tsq_state_e;
endpackage

// File: rtl/tsq_cfg_check.sv
module tsq_cfg_check
    import tsq_pkg::*;
(
    input  logic [CIDX_W-1:0]       ncomp,
    input  logic [NCOMP*SF_W-1:0]   hf,
    input  logic [NCOMP*SF_W-1:0]   vf,
    output logic [NCOMP*UNIT_W-1:0] unit_cnt,
    output logic                    cfg_ok
);
    int total;

    always_comb begin
        int hk;
        int vk;
        int cnt;
        cfg_ok   = 1'b1;
        total    = 0;
        unit_cnt = '0;
        if (int'(ncomp) == 0 || int'(ncomp) > NCOMP) begin
            cfg_ok = 1'b0;
        end
        for (int k = 0; k < NCOMP; k++) begin
            hk  = int'(hf[k*SF_W +: SF_W]);
            vk  = int'(vf[k*SF_W +: SF_W]);
            cnt = 0;
            if (k < int'(ncomp)) begin
                if (hk < 1 || hk > MAX_SF || vk < 1 || vk > MAX_SF) begin
                    cfg_ok = 1'b0;
                end
                cnt = (int'(ncomp) == 1) ? 1 : hk * vk;
            end
            total = total + cnt;
            unit_cnt[k*UNIT_W +: UNIT_W] = UNIT_W'(cnt);
        end
        if (total > MAX_UNITS) begin
            cfg_ok = 1'b0;
        end
    end

    // R8
    always_comb begin
        group_fits_chk: assert (!cfg_ok || (total >= 1 && total <= MAX_UNITS))
            else $error("accepted configuration does not fit the group limit");
    end
endmodule

// File: rtl/tsq_seq_fsm.sv
module tsq_seq_fsm
    import tsq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    advance,
    input  logic                    cfg_ok,
    input  logic [CIDX_W-1:0]       ncomp,
    input  logic [NCOMP*UNIT_W-1:0] unit_cnt,
    output logic [CIDX_W-1:0]       comp_out,
    output logic                    grp_last,
    output logic                    active,
    output logic                    fault
);
    tsq_state_e              state, state_n;
    logic [CIDX_W-1:0]       cur_comp, comp_n;
    logic [UNIT_W-1:0]       cur_unit, unit_n;
    logic [NCOMP*UNIT_W-1:0] cnt_q;
    logic [CIDX_W-1:0]       ncomp_q;
    logic [UNIT_W-1:0]       cur_cnt;
    logic                    unit_end;
    logic                    comp_end;

    always_comb begin
        cur_cnt = '0;
        for (int k = 0; k < NCOMP; k++) begin
            if (cur_comp == CIDX_W'(k)) begin
                cur_cnt = cnt_q[k*UNIT_W +: UNIT_W];
            end
        end
    end

    assign unit_end = (cur_unit == cur_cnt - UNIT_W'(1));
    assign comp_end = (cur_comp == ncomp_q - CIDX_W'(1));

    always_comb begin
        state_n = state;
        comp_n  = cur_comp;
        unit_n  = cur_unit;
        if (start) begin
            state_n = cfg_ok ? ST_RUN : ST_FAULT;
            comp_n  = '0;
            unit_n  = '0;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (advance) begin
                        if (unit_end) begin
                            unit_n = '0;
                            comp_n = comp_end ? '0 : cur_comp + CIDX_W'(1);
                        end else begin
                            unit_n = cur_unit + UNIT_W'(1);
                        end
                    end
                end
                ST_IDLE, ST_FAULT: begin
                    state_n = state;
                end
                default: begin
                    state_n = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_comp <= '0;
            cur_unit <= '0;
            cnt_q    <= '0;
            ncomp_q  <= '0;
        end else begin
            state    <= state_n;
            cur_comp <= comp_n;
            cur_unit <= unit_n;
            if (start) begin
                cnt_q   <= unit_cnt;
                ncomp_q <= ncomp;
            end
        end
    end

    always_comb begin
        comp_out = '0;
        grp_last = 1'b0;
        active   = 1'b0;
        fault    = 1'b0;
        unique case (state)
            ST_RUN: begin
                comp_out = cur_comp;
                grp_last = unit_end && comp_end;
                active   = 1'b1;
            end
            ST_FAULT: fault = 1'b1;
            default: ;
        endcase
    end

    // R2
    start_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cfg_ok) |=> (state == ST_RUN && cur_comp == '0 && cur_unit == '0));
    // R8
    start_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !cfg_ok) |=> (state == ST_FAULT));
    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && advance && grp_last) |=> (comp_out == '0 && cur_unit == '0 && active));
    // R3
    stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && advance && active && !unit_end) |=> $stable(cur_comp));
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && state != ST_RUN) |=> $stable(state));
endmodule

// File: rtl/tsq_id_mux.sv
module tsq_id_mux
    import tsq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   active,
    input  logic [CIDX_W-1:0]      comp,
    input  logic [NCOMP*TID_W-1:0] huff_in,
    input  logic [NCOMP*TID_W-1:0] quant_in,
    output logic [TID_W-1:0]       huff_out,
    output logic [TID_W-1:0]       quant_out
);
    logic [NCOMP*TID_W-1:0] huff_q;
    logic [NCOMP*TID_W-1:0] quant_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            huff_q  <= '0;
            quant_q <= '0;
        end else if (start) begin
            huff_q  <= huff_in;
            quant_q <= quant_in;
        end
    end

    always_comb begin
        huff_out  = '0;
        quant_out = '0;
        for (int k = 0; k < NCOMP; k++) begin
            if (active && comp == CIDX_W'(k)) begin
                huff_out  = huff_q[k*TID_W +: TID_W];
                quant_out = quant_q[k*TID_W +: TID_W];
            end
        end
    end

    // R1
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (huff_out == '0 && quant_out == '0));
endmodule

// File: rtl/tsq_top.sv
module tsq_top
    import tsq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   advance,
    input  logic [CIDX_W-1:0]      num_comp,
    input  logic [NCOMP*SF_W-1:0]  cfg_hf,
    input  logic [NCOMP*SF_W-1:0]  cfg_vf,
    input  logic [NCOMP*TID_W-1:0] cfg_huff,
    input  logic [NCOMP*TID_W-1:0] cfg_quant,
    output logic [CIDX_W-1:0]      comp_sel,
    output logic [TID_W-1:0]       huff_id,
    output logic [TID_W-1:0]       quant_id,
    output logic                   grp_last,
    output logic                   active,
    output logic                   cfg_fault
);
    logic [NCOMP*UNIT_W-1:0] unit_cnt;
    logic                    cfg_ok;

    tsq_cfg_check u_check (
        .ncomp    (num_comp),
        .hf       (cfg_hf),
        .vf       (cfg_vf),
        .unit_cnt (unit_cnt),
        .cfg_ok   (cfg_ok)
    );

    tsq_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .advance  (advance),
        .cfg_ok   (cfg_ok),
        .ncomp    (num_comp),
        .unit_cnt (unit_cnt),
        .comp_out (comp_sel),
        .grp_last (grp_last),
        .active   (active),
        .fault    (cfg_fault)
    );

    tsq_id_mux u_ids (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .active    (active),
        .comp      (comp_sel),
        .huff_in   (cfg_huff),
        .quant_in  (cfg_quant),
        .huff_out  (huff_id),
        .quant_out (quant_id)
    );
endmodule

// File: tb/tsq_top_tb.sv
module tsq_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       advance = 1'b0;
    logic [1:0] num_comp;
    logic [8:0] cfg_hf, cfg_vf;
    logic [5:0] cfg_huff, cfg_quant;
    logic [1:0] comp_sel, huff_id, quant_id;
    logic       grp_last, active, cfg_fault;

    int c_n = 1;
    int c_h[3] = '{1, 1, 1};
    int c_v[3] = '{1, 1, 1};
    int c_hid[3] = '{0, 0, 0};
    int c_qid[3] = '{0, 0, 0};

    always_comb begin
        num_comp = 2'(c_n);
        for (int k = 0; k < 3; k++) begin
            cfg_hf[k*3 +: 3]    = 3'(c_h[k]);
            cfg_vf[k*3 +: 3]    = 3'(c_v[k]);
            cfg_huff[k*2 +: 2]  = 2'(c_hid[k]);
            cfg_quant[k*2 +: 2] = 2'(c_qid[k]);
        end
    end

    tsq_top u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
        .num_comp(num_comp), .cfg_hf(cfg_hf), .cfg_vf(cfg_vf),
        .cfg_huff(cfg_huff), .cfg_quant(cfg_quant),
        .comp_sel(comp_sel), .huff_id(huff_id), .quant_id(quant_id),
        .grp_last(grp_last), .active(active), .cfg_fault(cfg_fault)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int tests = 0;
    int fails = 0;
    string tag = "R1";

    // reference model: 0 idle, 1 run, 2 fault
    int m_state = 0;
    int m_seq[$];
    int m_pos = 0;
    int m_hid[3];
    int m_qid[3];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0;
            m_seq.delete();
            m_pos = 0;
        end else if (start) begin
            bit ok;
            int tot;
            ok = (c_n >= 1 && c_n <= 3);
            tot = 0;
            m_seq.delete();
            for (int k = 0; k < c_n && k < 3; k++) begin
                if (c_h[k] < 1 || c_h[k] > 4 || c_v[k] < 1 || c_v[k] > 4) ok = 0;
                if (c_n == 1) begin
                    m_seq.push_back(0);
                end else begin
                    for (int u = 0; u < c_h[k] * c_v[k]; u++) m_seq.push_back(k);
                end
            end
            tot = m_seq.size();
            if (tot > 10) ok = 0;
            for (int k = 0; k < 3; k++) begin
                m_hid[k] = c_hid[k];
                m_qid[k] = c_qid[k];
            end
            m_pos = 0;
            m_state = ok ? 1 : 2;
        end else if (m_state == 1 && advance) begin
            m_pos = (m_pos + 1) % m_seq.size();
        end
    end

    task automatic chk(string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        int ec, eh, eq, el;
        ec = 0; eh = 0; eq = 0; el = 0;
        if (m_state == 1) begin
            ec = m_seq[m_pos];
            eh = m_hid[ec];
            eq = m_qid[ec];
            el = (m_pos == m_seq.size() - 1) ? 1 : 0;
        end
        chk("comp_sel", int'(comp_sel), ec);
        chk("huff_id", int'(huff_id), eh);
        chk("quant_id", int'(quant_id), eq);
        chk("grp_last", int'(grp_last), el);
        chk("active", int'(active), (m_state == 1) ? 1 : 0);
        chk("cfg_fault", int'(cfg_fault), (m_state == 2) ? 1 : 0);
    end

    task automatic cyc(bit s, bit a);
        @(negedge clk);
        #1;
        start = s;
        advance = a;
    endtask

    task automatic set_cfg(int n, int h0, int v0, int h1, int v1, int h2, int v2);
        c_n = n;
        c_h[0] = h0; c_v[0] = v0;
        c_h[1] = h1; c_v[1] = v1;
        c_h[2] = h2; c_v[2] = v2;
    endtask

    task automatic set_ids(int a0, int b0, int a1, int b1, int a2, int b2);
        c_hid[0] = a0; c_qid[0] = b0;
        c_hid[1] = a1; c_qid[1] = b1;
        c_hid[2] = a2; c_qid[2] = b2;
    endtask

    task automatic run_adv(int n, bit gaps);
        for (int i = 0; i < n; i++) begin
            cyc(0, 1);
            if (gaps && (i % 3 == 1)) cyc(0, 0);
        end
        cyc(0, 0);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", wd, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then idle with advance ignored (R9)
        tag = "R1";
        repeat (3) cyc(0, 0);
        rst_n = 1'b1;
        tag = "R9";
        cyc(0, 1); cyc(0, 1); cyc(0, 0);

        // R2 R3 R5 R6: three components 2x2,1x1,1x1
        tag = "R3";
        set_cfg(3, 2, 2, 1, 1, 1, 1);
        set_ids(1, 2, 3, 0, 2, 3);
        cyc(1, 0);
        // R4: configuration changes after start have no effect
        set_ids(0, 1, 1, 1, 0, 0);
        set_cfg(2, 4, 4, 4, 4, 4, 4);
        tag = "R6";
        run_adv(14, 1'b1);

        // R3 R5: two components 1x2 and 3x1
        tag = "R5";
        set_cfg(2, 1, 2, 3, 1, 1, 1);
        set_ids(3, 3, 1, 2, 0, 0);
        cyc(1, 0);
        run_adv(11, 1'b1);

        // R7: single component, factors ignored
        tag = "R7";
        set_cfg(1, 4, 2, 1, 1, 1, 1);
        set_ids(2, 1, 3, 3, 3, 3);
        cyc(1, 0);
        run_adv(5, 1'b0);

        // R8: eleven units rejected, advance ignored in fault
        tag = "R8";
        set_cfg(3, 3, 3, 1, 1, 1, 1);
        cyc(1, 0);
        run_adv(3, 1'b0);
        // factor 5 rejected
        set_cfg(2, 5, 1, 1, 1, 1, 1);
        cyc(1, 0); cyc(0, 0);
        // zero components rejected
        set_cfg(0, 1, 1, 1, 1, 1, 1);
        cyc(1, 0); cyc(0, 0);
        // factor 0 on a used component rejected
        set_cfg(3, 1, 1, 1, 1, 0, 1);
        cyc(1, 0); cyc(0, 0);

        // R2: recovery and ten-unit boundary 4x2+1+1, start wins over advance (R9)
        tag = "R2";
        set_cfg(3, 4, 2, 1, 1, 1, 1);
        set_ids(0, 3, 1, 2, 2, 1);
        cyc(1, 1);
        tag = "R6";
        run_adv(12, 1'b0);
        tag = "R9";
        cyc(0, 1); cyc(0, 1); cyc(1, 1); cyc(0, 0);
        run_adv(4, 1'b0);

        // R1: reset during run
        tag = "R1";
        cyc(0, 0);
        rst_n = 1'b0;
        cyc(0, 1); cyc(0, 0);
        rst_n = 1'b1;
        cyc(0, 0); cyc(0, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule